// File: doc/BRIEF.md
# Tight-Loop Instruction Fetch Gate

This block sits beside an instruction prefetch path. It watches decode and execute events for a very short loop: one one-word operand instruction followed by a two-word decrement-and-branch instruction that jumps back to it. Once the loop has been seen and confirmed, the block blocks every instruction fetch request. Only operand reads and writes then reach the bus, until the loop ends.

Detection takes two passes. In the first pass the executed eligible instruction is followed by a taken loop-branch whose displacement is exactly -4. That pattern arms the block. In the second pass the looped word is fetched again and decoded as eligible, and loop mode starts on the next cycle. The loop is left in these cases:
- the branch falls through;
- an interrupt is accepted, which the block allows only at a loop-branch while looping;
- tracing is switched on;
- reset.

A bus error suspends the loop. When the exception returns, the loop resumes at once without refetching the three loop words.

Top module: `loop_fetch_gate`

## Requirements
- R1: After reset `loop_act` is 0 and `fetch_req` equals `fetch_want`.
- R2: The block arms only when an executed loop-branch has all four of these: it is taken, its displacement is 16'hFFFC, the previously executed instruction was flagged eligible, and `trace_en` is low. After arming, a decode event with `dec_elig`=1 raises `loop_act` on the following cycle.
- R3: Any other displacement, a not-taken branch, or a non-eligible previous instruction leaves `loop_act` at 0.
- R4: While `trace_en` is 1, `loop_act` is 0, and a loop in progress ends in that same cycle.
- R5: While `loop_act` is 1, `fetch_req` is 0 whatever `fetch_want` is.
- R6: A loop-branch executed with `br_taken`=0 drops `loop_act` and lets `fetch_req` follow `fetch_want` in that same cycle.
- R7: While looping, `irq_win` rises only on an executed loop-branch with `irq_pend`=1, never on the looped instruction. Accepting the interrupt ends the loop. Re-entry needs the full two-pass pattern again.
- R8: Outside a loop, `irq_win` equals `irq_pend` on any cycle with `ex_valid`=1, and is 0 otherwise.
- R9: `bus_err` during a loop drops `loop_act` in that cycle and lets fetches pass. The next `exc_ret` restores `loop_act` on the following cycle, with no refetch or redetection.
- R10: An armed block that sees a decode event with `dec_elig`=0 disarms. A later eligible decode alone then does not start a loop.
- R11: From the start of the first pass to loop entry, exactly five instruction fetch requests pass: three words, then two refetched words. None pass while the loop runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_want | input | 1 | Prefetch unit wants an instruction fetch cycle |
| fetch_req | output | 1 | Fetch request allowed onto the bus |
| dec_valid | input | 1 | A word enters the decode register |
| dec_elig | input | 1 | That word is a loop-eligible one-word instruction |
| ex_valid | input | 1 | An instruction completes this cycle |
| ex_elig | input | 1 | Completing instruction is loop-eligible |
| ex_dbr | input | 1 | Completing instruction is the decrement-and-branch |
| ex_disp | input | 16 | Branch displacement of the completing loop-branch |
| br_taken | input | 1 | Branch unit: count not exhausted and condition false |
| irq_pend | input | 1 | An interrupt is pending |
| trace_en | input | 1 | Trace mode enabled |
| bus_err | input | 1 | Bus error reported this cycle |
| exc_ret | input | 1 | Return from exception into the suspended looped instruction |
| loop_act | output | 1 | Loop mode active |
| irq_win | output | 1 | Interrupt may be accepted at this boundary |

## Verification
A block that believes it is looping when it is not shows up at once on `fetch_req`: the bench keeps `fetch_want` high and sees requests vanish in the very cycle `loop_act` rises wrongly. A block that is wrongly armed or idle shows up one cycle after the second-pass eligible decode, as a missing or extra `loop_act`. A wrong suspended state shows up one cycle after `exc_ret`. The bench sweeps displacement, taken, previous-eligibility and trace combinations and compares each case with the arithmetic entry rule. It also counts fetch requests across a full entry.

// File: rtl/loop_fetch_gate.sv
module loop_fetch_gate #(
  parameter int DISP_W    = 16,
  parameter int LOOP_BACK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_want,
  output logic              fetch_req,
  input  logic              dec_valid,
  input  logic              dec_elig,
  input  logic              ex_valid,
  input  logic              ex_elig,
  input  logic              ex_dbr,
  input  logic [DISP_W-1:0] ex_disp,
  input  logic              br_taken,
  input  logic              irq_pend,
  input  logic              trace_en,
  input  logic              bus_err,
  input  logic              exc_ret,
  output logic              loop_act,
  output logic              irq_win
);

  localparam logic [DISP_W-1:0] TGT_DISP = DISP_W'(-LOOP_BACK);
  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_ARMED = 2'd1;
  localparam logic [1:0] S_LOOP  = 2'd2;
  localparam logic [1:0] S_HOLD  = 2'd3;

  logic [1:0] st_q, st_d;
  logic       prev_elig_q;

  wire in_loop    = (st_q == S_LOOP);
  wire pattern_ok = ex_valid & ex_dbr & br_taken & prev_elig_q & ~trace_en
                  & (ex_disp == TGT_DISP);
  wire fall_thru  = ex_valid & ex_dbr & ~br_taken;

  assign irq_win   = irq_pend & ex_valid & (~in_loop | ex_dbr);

  wire loop_break = in_loop & (trace_en | irq_win | fall_thru | bus_err);

  assign loop_act  = in_loop & ~loop_break;
  assign fetch_req = fetch_want & ~loop_act;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (pattern_ok) st_d = S_ARMED;
      S_ARMED: begin
        if (trace_en | bus_err | ex_valid) st_d = S_IDLE;
        else if (dec_valid)                st_d = dec_elig ? S_LOOP : S_IDLE;
      end
      S_LOOP: begin
        if (bus_err)         st_d = S_HOLD;
        else if (loop_break) st_d = S_IDLE;
      end
      default: if (exc_ret) st_d = S_LOOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      prev_elig_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ex_valid) prev_elig_q <= ex_elig;
    end
  end

endmodule

// File: rtl/loop_fetch_gate_chk.sv
module loop_fetch_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_req,
  input logic       loop_act,
  input logic       irq_win,
  input logic       ex_valid,
  input logic       ex_dbr,
  input logic       br_taken,
  input logic       dec_valid,
  input logic       dec_elig,
  input logic       trace_en,
  input logic       bus_err,
  input logic       exc_ret,
  input logic [1:0] st_q
);

  p_nofetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_act |-> !fetch_req);

  p_irq_at_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd2 && irq_win) |-> ex_dbr);

  p_entry_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd2 && $past(st_q) == 2'd1) |-> $past(dec_valid && dec_elig));

  p_trace_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |-> !loop_act);

  p_fall_thru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_dbr && !br_taken) |-> !loop_act);

  p_berr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd2 && bus_err) |=> (st_q == 2'd3 && !loop_act));

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd3 && exc_ret) |=> (st_q == 2'd2));

endmodule

bind loop_fetch_gate loop_fetch_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .loop_act(loop_act),
  .irq_win(irq_win), .ex_valid(ex_valid), .ex_dbr(ex_dbr), .br_taken(br_taken),
  .dec_valid(dec_valid), .dec_elig(dec_elig), .trace_en(trace_en),
  .bus_err(bus_err), .exc_ret(exc_ret), .st_q(st_q)
);

// File: tb/loop_fetch_gate_bench.sv
module loop_fetch_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_want, dec_valid, dec_elig, ex_valid, ex_elig, ex_dbr, br_taken;
  logic irq_pend, trace_en, bus_err, exc_ret;
  logic [15:0] ex_disp;
  logic fetch_req, loop_act, irq_win;
  int total = 0, bad = 0, nfetch = 0;

  always #10 clk = ~clk;

  loop_fetch_gate u_loop_fetch_gate (
    .clk(clk), .rst_n(rst_n), .fetch_want(fetch_want), .fetch_req(fetch_req),
    .dec_valid(dec_valid), .dec_elig(dec_elig), .ex_valid(ex_valid),
    .ex_elig(ex_elig), .ex_dbr(ex_dbr), .ex_disp(ex_disp), .br_taken(br_taken),
    .irq_pend(irq_pend), .trace_en(trace_en), .bus_err(bus_err),
    .exc_ret(exc_ret), .loop_act(loop_act), .irq_win(irq_win)
  );

  always @(negedge clk) if (fetch_req) nfetch++;

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic clr();
    fetch_want = 0; dec_valid = 0; dec_elig = 0; ex_valid = 0; ex_elig = 0;
    ex_dbr = 0; ex_disp = 16'h0; br_taken = 0; irq_pend = 0; bus_err = 0;
    exc_ret = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1; clr(); #2;
  endtask

  task automatic do_reset();
    clr(); trace_en = 0; rst_n = 0;
    @(posedge clk); #1; rst_n = 1; #2;
  endtask

  task automatic f();
    fetch_want = 1; cyc();
  endtask

  task automatic d(input logic e);
    dec_valid = 1; dec_elig = e; cyc();
  endtask

  task automatic x(input logic e, input logic db, input logic [15:0] dp, input logic tk);
    ex_valid = 1; ex_elig = e; ex_dbr = db; ex_disp = dp; br_taken = tk; cyc();
  endtask

  task automatic enter();
    f(); d(1); f(); f(); x(1, 0, 16'h0, 0); x(0, 1, 16'hFFFC, 1);
    f(); f(); d(1);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr(); trace_en = 0;
    #1;
    fetch_want = 1; #1;
    chk(loop_act, 0, "R1 loop_act in reset");
    chk(fetch_req, 1, "R1 fetch passes in reset");
    do_reset();
    fetch_want = 1; #1;
    chk(fetch_req, 1, "R1 fetch passes after reset");
    clr();

    // R2 R3 R4 sweep: entry iff disp==-4, taken, previous eligible, no trace
    for (int di = 0; di < 6; di++)
      for (int c = 0; c < 8; c++) begin
        logic tk, pe, tr, exp_loop;
        logic [15:0] dp;
        dp = 16'(-8 + 2 * di);
        tk = c[0]; pe = c[1]; tr = c[2];
        exp_loop = (dp == 16'hFFFC) && tk && pe && !tr;
        do_reset();
        x(pe, 0, 16'h0, 0);
        trace_en = tr; x(0, 1, dp, tk); trace_en = 0;
        f(); f(); d(1);
        chk(loop_act, exp_loop, $sformatf("R2/R3/R4 entry disp=%0d tk=%0b pe=%0b tr=%0b",
            $signed(dp), tk, pe, tr));
      end

    // R11 fetch count across entry, R5 no fetch while looping
    do_reset();
    nfetch = 0;
    enter();
    chk(nfetch == 5, 1, "R11 five fetches up to entry");
    chk(loop_act, 1, "R2 loop active after second-pass decode");
    for (int i = 0; i < 4; i++) begin
      fetch_want = 1; ex_valid = 1; ex_elig = 1; #1;
      chk(fetch_req, 0, "R5 fetch blocked at looped instruction");
      cyc();
      fetch_want = 1; ex_valid = 1; ex_dbr = 1; ex_disp = 16'hFFFC; br_taken = 1; #1;
      chk(fetch_req, 0, "R5 fetch blocked at loop-branch");
      cyc();
    end
    chk(nfetch == 5, 1, "R11 zero fetches while looping");

    // R6 fall-through exit
    fetch_want = 1; ex_valid = 1; ex_dbr = 1; ex_disp = 16'hFFFC; br_taken = 0; #1;
    chk(loop_act, 0, "R6 loop_act drops on fall-through");
    chk(fetch_req, 1, "R6 fetch resumes on fall-through");
    cyc();
    fetch_want = 1; #1;
    chk(loop_act, 0, "R6 stays idle after exit");
    chk(fetch_req, 1, "R6 fetch passes after exit");
    clr();

    // R7 interrupt window only at loop-branch
    do_reset();
    enter();
    irq_pend = 1; ex_valid = 1; ex_elig = 1; #1;
    chk(irq_win, 0, "R7 no window at looped instruction");
    chk(loop_act, 1, "R7 loop kept at looped instruction");
    cyc();
    irq_pend = 1; ex_valid = 1; ex_dbr = 1; ex_disp = 16'hFFFC; br_taken = 1; #1;
    chk(irq_win, 1, "R7 window at loop-branch");
    chk(loop_act, 0, "R7 accept ends loop");
    cyc();
    d(1);
    chk(loop_act, 0, "R7 no re-entry without pattern");
    enter();
    chk(loop_act, 1, "R7 re-entry after full pattern");

    // R4 trace ends a running loop
    trace_en = 1; fetch_want = 1; #1;
    chk(loop_act, 0, "R4 trace ends loop");
    chk(fetch_req, 1, "R4 fetch passes under trace");
    cyc(); trace_en = 0; #1;
    chk(loop_act, 0, "R4 loop stays ended");

    // R8 window outside loop
    irq_pend = 1; ex_valid = 1; ex_elig = 1; #1;
    chk(irq_win, 1, "R8 window at any executed instruction");
    clr(); irq_pend = 1; #1;
    chk(irq_win, 0, "R8 no window without execution");
    clr();

    // R9 bus error suspend and resume
    do_reset();
    enter();
    bus_err = 1; fetch_want = 1; #1;
    chk(loop_act, 0, "R9 bus error drops loop_act");
    chk(fetch_req, 1, "R9 fetch passes at bus error");
    cyc();
    fetch_want = 1; #1;
    chk(fetch_req, 1, "R9 handler fetches pass");
    cyc();
    exc_ret = 1; cyc();
    fetch_want = 1; #1;
    chk(loop_act, 1, "R9 loop resumes after return");
    chk(fetch_req, 0, "R9 no refetch after return");
    clr();

    // R10 armed then non-eligible decode
    do_reset();
    x(1, 0, 16'h0, 0); x(0, 1, 16'hFFFC, 1);
    d(0);
    chk(loop_act, 0, "R10 disarmed by non-eligible decode");
    d(1);
    chk(loop_act, 0, "R10 later eligible decode alone no entry");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule